// File: doc/BRIEF.md
# DMA Master Transfer Attribute Generator

This block sequences the address phases of one DMA channel on a pipelined AHB-style master port. For each phase it selects the attributes: protection bits, transfer size, direction, lock and transfer type. A channel runs in one of two orders. It can fetch a linked-list descriptor, then read the source, then write the destination. It can also skip the descriptor fetch and start directly with the source reads. Each stage issues a programmable number of beats. A beat is accepted only on a cycle where `hready` is high.

During a descriptor fetch the protection attributes ignore the channel's programmed values. They are forced to privileged, non-bufferable and cacheable, with a word-sized transfer. Source reads and destination writes use the programmed protection bits and take their size from the matching width setting. Address generation, arbitration, data movement and burst splitting are done by neighbouring logic.

The states are IDLE, DESC (descriptor load), SRC (source read) and DST (destination write). The transitions are:
- IDLE goes to DESC when `desc_req` is high, and to SRC when only `xfer_req` is high.
- DESC goes to SRC after its last beat is accepted.
- SRC goes to DST after its last beat is accepted.
- DST goes back to IDLE after its last beat is accepted.

Top module: `dma_xfer_attr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to IDLE. In IDLE, `htrans` is 2'b00 and `hlock` is 0, whatever the request and lock inputs are.
- R2: `hprot[0]` is 1 on every issued beat, which marks the beat as a data access.
- R3: In DESC, `hprot` is 4'b1011 (bit3 cacheable=1, bit2 bufferable=0, bit1 privileged=1, bit0=1). In DESC, `hsize` is 3'b010 (word) and `hwrite` is 0, regardless of the channel settings.
- R4: In SRC, `hwrite` is 0 and `hsize` is {1'b0, `cfg_src_width`}, where width code 0 is byte, 1 is halfword and 2 is word. `hprot` is {`cfg_cache`, `cfg_buf`, `cfg_priv`, 1}.
- R5: In DST, `hwrite` is 1 and `hsize` is {1'b0, `cfg_dst_width`}. `hprot` is {`cfg_cache`, `cfg_buf`, `cfg_priv`, 1}.
- R6: `hlock` equals `cfg_lock` whenever `htrans` is not IDLE. `hlock` is 0 whenever `htrans` is IDLE.
- R7: While a beat is pending and `hready` is low, the next cycle shows the same `htrans` and `hwrite`. The beat is not counted.
- R8: A stage whose beat field holds N issues N+1 beats. The first beat is NONSEQ (2'b10) and the rest are SEQ (2'b11).
- R9: After the last DST beat is accepted, the block returns to IDLE (`htrans`=2'b00) on the next cycle. Stages always run in the order DESC, SRC, DST.
- R10: Requests are sampled only in IDLE, and `desc_req` wins over `xfer_req`. Requests that arrive while a transfer is running are ignored. With no request in IDLE, the block stays in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| desc_req | input | 1 | Start with a descriptor fetch |
| xfer_req | input | 1 | Start directly with source reads |
| hready | input | 1 | Bus ready; a beat is accepted when high |
| cfg_priv | input | 1 | Programmed privileged bit |
| cfg_buf | input | 1 | Programmed bufferable bit |
| cfg_cache | input | 1 | Programmed cacheable bit |
| cfg_lock | input | 1 | Lock the channel's transfers |
| cfg_src_width | input | 2 | Source width code (0 byte, 1 half, 2 word) |
| cfg_dst_width | input | 2 | Destination width code |
| cfg_desc_beats | input | BEAT_W | Descriptor beats minus one |
| cfg_src_beats | input | BEAT_W | Source beats minus one |
| cfg_dst_beats | input | BEAT_W | Destination beats minus one |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Write direction |
| hsize | output | 3 | Transfer size |
| hprot | output | 4 | Protection attributes |
| hlock | output | 1 | Locked transfer |

## Verification
The assertions check on every cycle the properties that depend only on the current state:
- the forced descriptor attributes;
- the size and direction chosen for each data stage;
- lock being low in IDLE;
- the hold of `htrans` and `hwrite` during wait states;
- SEQ never following IDLE, and the return to IDLE after writes;
- staying in IDLE when there is no request.

Only the bench's scenarios can show the exact beat count of each stage and the full stage order. They also show the priority between simultaneous requests, and that requests arriving mid-transfer leave the expected beat stream unchanged.

// File: rtl/dxa_pkg.sv
package dxa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DESC = 2'd1,
        ST_SRC  = 2'd2,
        ST_DST  = 2'd3
    } phase_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [1:0] WID_WORD  = 2'd2;
    localparam logic [3:0] PROT_DESC = 4'b1011;
endpackage

// File: rtl/dxa_beat_cnt.sv
module dxa_beat_cnt #(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              hready,
    input  logic [BEAT_W-1:0] limit,
    output logic              first,
    output logic              last
);
    logic [BEAT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (active && hready) begin
            if (cnt == limit) cnt <= '0;
            else              cnt <= cnt + 1'b1;
        end
    end

    assign first = (cnt == '0);
    assign last  = (cnt == limit);
endmodule

// File: rtl/dxa_seq_fsm.sv
module dxa_seq_fsm
    import dxa_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_req,
    input  logic              xfer_req,
    input  logic              hready,
    input  logic              beat_last,
    input  logic [BEAT_W-1:0] desc_beats,
    input  logic [BEAT_W-1:0] src_beats,
    input  logic [BEAT_W-1:0] dst_beats,
    output phase_e            phase,
    output logic              active,
    output logic [BEAT_W-1:0] beat_lim
);
    phase_e state_q, state_d;
    logic   stage_done;

    assign stage_done = hready && beat_last;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        beat_lim = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (desc_req)      state_d = ST_DESC;
                else if (xfer_req) state_d = ST_SRC;
            end
            ST_DESC: begin
                beat_lim = desc_beats;
                if (stage_done) state_d = ST_SRC;
            end
            ST_SRC: begin
                beat_lim = src_beats;
                if (stage_done) state_d = ST_DST;
            end
            ST_DST: begin
                beat_lim = dst_beats;
                if (stage_done) state_d = ST_IDLE;
            end
        endcase
    end

    assign phase  = state_q;
    assign active = (state_q != ST_IDLE);
endmodule

// File: rtl/dxa_attr_mux.sv
module dxa_attr_mux
    import dxa_pkg::*;
(
    input  phase_e      phase,
    input  logic        first,
    input  logic        cfg_priv,
    input  logic        cfg_buf,
    input  logic        cfg_cache,
    input  logic        cfg_lock,
    input  logic [1:0]  cfg_src_width,
    input  logic [1:0]  cfg_dst_width,
    output logic [1:0]  htrans,
    output logic        hwrite,
    output logic [2:0]  hsize,
    output logic [3:0]  hprot,
    output logic        hlock
);
    logic [3:0] prog_prot;

    assign prog_prot = {cfg_cache, cfg_buf, cfg_priv, 1'b1};

    always_comb begin
        htrans = first ? TR_NONSEQ : TR_SEQ;
        hwrite = 1'b0;
        hsize  = {1'b0, WID_WORD};
        hprot  = prog_prot;
        hlock  = cfg_lock;
        unique case (phase)
            ST_IDLE: begin
                htrans = TR_IDLE;
                hlock  = 1'b0;
            end
            ST_DESC: begin
                hprot = PROT_DESC;
                hsize = {1'b0, WID_WORD};
            end
            ST_SRC: begin
                hsize = {1'b0, cfg_src_width};
            end
            ST_DST: begin
                hwrite = 1'b1;
                hsize  = {1'b0, cfg_dst_width};
            end
        endcase
    end
endmodule

// File: rtl/dma_xfer_attr_gen.sv
module dma_xfer_attr_gen
    import dxa_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_req,
    input  logic              xfer_req,
    input  logic              hready,
    input  logic              cfg_priv,
    input  logic              cfg_buf,
    input  logic              cfg_cache,
    input  logic              cfg_lock,
    input  logic [1:0]        cfg_src_width,
    input  logic [1:0]        cfg_dst_width,
    input  logic [BEAT_W-1:0] cfg_desc_beats,
    input  logic [BEAT_W-1:0] cfg_src_beats,
    input  logic [BEAT_W-1:0] cfg_dst_beats,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [3:0]        hprot,
    output logic              hlock
);
    phase_e            phase;
    logic              active;
    logic              beat_first;
    logic              beat_last;
    logic [BEAT_W-1:0] beat_lim;

    dxa_seq_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_req   (desc_req),
        .xfer_req   (xfer_req),
        .hready     (hready),
        .beat_last  (beat_last),
        .desc_beats (cfg_desc_beats),
        .src_beats  (cfg_src_beats),
        .dst_beats  (cfg_dst_beats),
        .phase      (phase),
        .active     (active),
        .beat_lim   (beat_lim)
    );

    dxa_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .hready (hready),
        .limit  (beat_lim),
        .first  (beat_first),
        .last   (beat_last)
    );

    dxa_attr_mux u_mux (
        .phase         (phase),
        .first         (beat_first),
        .cfg_priv      (cfg_priv),
        .cfg_buf       (cfg_buf),
        .cfg_cache     (cfg_cache),
        .cfg_lock      (cfg_lock),
        .cfg_src_width (cfg_src_width),
        .cfg_dst_width (cfg_dst_width),
        .htrans        (htrans),
        .hwrite        (hwrite),
        .hsize         (hsize),
        .hprot         (hprot),
        .hlock         (hlock)
    );
endmodule

// File: rtl/dxa_chk.sv
module dxa_chk
    import dxa_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       desc_req,
    input logic       xfer_req,
    input logic       hready,
    input logic [1:0] cfg_src_width,
    input logic [1:0] cfg_dst_width,
    input phase_e     phase,
    input logic [1:0] htrans,
    input logic       hwrite,
    input logic [2:0] hsize,
    input logic [3:0] hprot,
    input logic       hlock
);
    // R3
    desc_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == ST_DESC |-> hprot == 4'b1011 && hsize == 3'b010 && !hwrite);

    // R4
    src_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == ST_SRC |-> !hwrite && hsize == {1'b0, cfg_src_width});

    // R5
    dst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == ST_DST |-> hwrite && hsize == {1'b0, cfg_dst_width});

    // R6
    idle_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_IDLE |-> !hlock);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrans != TR_IDLE && !hready |=> $stable(htrans) && $stable(hwrite));

    // R8
    seq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_SEQ |-> $past(htrans) != TR_IDLE);

    // R9
    write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hwrite) |-> htrans == TR_IDLE);

    // R10
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_IDLE && !desc_req && !xfer_req |=> htrans == TR_IDLE);
endmodule

bind dma_xfer_attr_gen dxa_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .desc_req      (desc_req),
    .xfer_req      (xfer_req),
    .hready        (hready),
    .cfg_src_width (cfg_src_width),
    .cfg_dst_width (cfg_dst_width),
    .phase         (phase),
    .htrans        (htrans),
    .hwrite        (hwrite),
    .hsize         (hsize),
    .hprot         (hprot),
    .hlock         (hlock)
);

// File: tb/tb_dma_xfer_attr_gen.sv
`timescale 1ns/1ps
module tb_dma_xfer_attr_gen;
    localparam int BW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic desc_req = 1'b0, xfer_req = 1'b0, hready = 1'b1;
    logic cfg_priv = 1'b0, cfg_buf = 1'b0, cfg_cache = 1'b0, cfg_lock = 1'b0;
    logic [1:0] cfg_src_width = 2'd0, cfg_dst_width = 2'd0;
    logic [BW-1:0] cfg_desc_beats = '0, cfg_src_beats = '0, cfg_dst_beats = '0;
    logic [1:0] htrans;
    logic hwrite, hlock;
    logic [2:0] hsize;
    logic [3:0] hprot;

    always #4 clk = ~clk;

    dma_xfer_attr_gen #(.BEAT_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .desc_req(desc_req), .xfer_req(xfer_req),
        .hready(hready), .cfg_priv(cfg_priv), .cfg_buf(cfg_buf),
        .cfg_cache(cfg_cache), .cfg_lock(cfg_lock),
        .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
        .cfg_desc_beats(cfg_desc_beats), .cfg_src_beats(cfg_src_beats),
        .cfg_dst_beats(cfg_dst_beats), .htrans(htrans), .hwrite(hwrite),
        .hsize(hsize), .hprot(hprot), .hlock(hlock)
    );

    typedef struct packed {
        logic [1:0] ph;   // 1 desc, 2 src, 3 dst
        logic [1:0] tr;
        logic       wr;
        logic [2:0] sz;
        logic [3:0] pr;
        logic       lk;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit stall_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // hready pattern driver
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        hready = stall_en ? lfsr[0] : 1'b1;
    end

    // push expected beats of one stage
    task automatic push_stage(input logic [1:0] ph, input logic [BW-1:0] n);
        for (int i = 0; i <= int'(n); i++) begin
            exp_t e;
            e.ph = ph;
            e.tr = (i == 0) ? 2'b10 : 2'b11;
            e.wr = (ph == 2'd3);
            e.sz = (ph == 2'd1) ? 3'b010 :
                   (ph == 2'd2) ? {1'b0, cfg_src_width} : {1'b0, cfg_dst_width};
            e.pr = (ph == 2'd1) ? 4'b1011 : {cfg_cache, cfg_buf, cfg_priv, 1'b1};
            e.lk = cfg_lock;
            exp_q.push_back(e);
        end
    endtask

    // monitor / scoreboard
    logic       stall_pend = 1'b0;
    logic [1:0] stall_tr;
    logic       stall_wr;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pend) begin
                chk(htrans == stall_tr, "R7", "htrans held in wait", htrans, stall_tr);
                chk(hwrite == stall_wr, "R7", "hwrite held in wait", hwrite, stall_wr);
                stall_pend = 1'b0;
            end
            if (htrans != 2'b00) begin
                if (!hready) begin
                    stall_pend = 1'b1;
                    stall_tr = htrans;
                    stall_wr = hwrite;
                end else if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected beat", htrans, 2'b00);
                end else begin
                    exp_t e;
                    string rq;
                    e = exp_q.pop_front();
                    rq = (e.ph == 2'd1) ? "R3" : (e.ph == 2'd2) ? "R4" : "R5";
                    chk(htrans == e.tr, "R8", "htrans", htrans, e.tr);
                    chk(hwrite == e.wr, rq, "hwrite", hwrite, e.wr);
                    chk(hsize == e.sz, rq, "hsize", hsize, e.sz);
                    chk(hprot == e.pr, rq, "hprot", hprot, e.pr);
                    chk(hprot[0] == 1'b1, "R2", "hprot[0]", hprot[0], 1'b1);
                    chk(hlock == e.lk, "R6", "hlock", hlock, e.lk);
                end
            end else begin
                chk(hlock == 1'b0, "R6", "hlock in idle", hlock, 1'b0);
            end
        end
    end

    task automatic wait_done();
        while (exp_q.size() != 0) @(posedge clk);
        #1;
        @(negedge clk);
        chk(htrans == 2'b00, "R9", "idle after writes", htrans, 2'b00);
    endtask

    task automatic run(input bit d, input bit x);
        if (d) push_stage(2'd1, cfg_desc_beats);
        push_stage(2'd2, cfg_src_beats);
        push_stage(2'd3, cfg_dst_beats);
        @(posedge clk); #1;
        desc_req = d; xfer_req = x;
        @(posedge clk); #1;
        desc_req = 1'b0; xfer_req = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual=hung expected=idle");
        report();
        $finish;
    end

    initial begin
        // R1: reset with request and lock high
        cfg_lock = 1'b1; desc_req = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(htrans == 2'b00, "R1", "htrans in reset", htrans, 2'b00);
        chk(hlock == 1'b0, "R1", "hlock in reset", hlock, 1'b0);
        @(posedge clk); #1;
        desc_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(htrans == 2'b00, "R1", "idle after reset", htrans, 2'b00);

        // descriptor chain, no wait states
        cfg_priv = 1'b0; cfg_buf = 1'b1; cfg_cache = 1'b0; cfg_lock = 1'b1;
        cfg_src_width = 2'd0; cfg_dst_width = 2'd1;
        cfg_desc_beats = 4'd3; cfg_src_beats = 4'd2; cfg_dst_beats = 4'd0;
        run(1'b1, 1'b0);
        wait_done();

        // direct transfer with wait states
        stall_en = 1'b1;
        cfg_lock = 1'b0; cfg_src_width = 2'd2; cfg_dst_width = 2'd0;
        cfg_src_beats = 4'd0; cfg_dst_beats = 4'd4;
        run(1'b0, 1'b1);
        wait_done();

        // R10: both requests together, descriptor first, with stalls
        cfg_priv = 1'b1; cfg_buf = 1'b1; cfg_cache = 1'b1; cfg_lock = 1'b1;
        cfg_desc_beats = 4'd1; cfg_src_beats = 4'd5; cfg_dst_beats = 4'd2;
        run(1'b1, 1'b1);
        wait_done();

        // R10: requests during a running transfer are ignored
        stall_en = 1'b0;
        cfg_lock = 1'b0; cfg_buf = 1'b0;
        cfg_desc_beats = 4'd2; cfg_src_beats = 4'd3; cfg_dst_beats = 4'd3;
        run(1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1; desc_req = 1'b1; xfer_req = 1'b1;
        @(posedge clk); #1; desc_req = 1'b0; xfer_req = 1'b0;
        wait_done();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(htrans == 2'b00, "R10", "idle with no request", htrans, 2'b00);
        end
        chk(exp_q.size() == 0, "R10", "no extra beats", exp_q.size(), 0);

        report();
        $finish;
    end
endmodule